// File: doc/BRIEF.md
# Operand Bypass Select and Load-Dependency Stall Unit

This unit is the hazard logic of an in-order five-stage pipeline (fetch, decode, execute, memory, writeback). For the instruction in the execute stage it chooses, separately for each of the two ALU operands, whether the value comes from the register file or is bypassed from one of the two later pipeline registers. It compares the source register numbers of that instruction with the destination number and write-enable held by the execute/memory register and by the memory/writeback register. If both later stages target the same register, the younger producer wins.

The unit also watches for a load in execute whose destination is read by the instruction in decode. On that hazard it stops the program counter and the fetch/decode register for one cycle, and it asks the execute register to take a bubble with its control bits cleared. A cycle later the load sits in the memory/writeback register and the waiting instruction takes its data through the bypass. The pipeline registers themselves, the ALU, the data memory and branch handling sit outside this unit. Register zero is wired to read zero by default; a parameter can make it an ordinary register.

Top module: `fwd_hazard_unit`

## Requirements
- R1: An operand select reads 2'b10 (bypass from execute/memory) whenever that stage's write-enable is 1, its destination is not register zero, and the destination equals the operand's source register.
- R2: An operand select reads 2'b01 (bypass from memory/writeback) when the same three conditions hold for the memory/writeback stage and R1 does not hold for that operand. If both stages match, the select is 2'b10.
- R3: The two operand selects (A from the rs field, B from the rt field) are worked out independently. They may differ, or both may bypass from the same stage.
- R4: A producer whose write-enable is 0, such as a store, a branch or a bubble, never causes a bypass, whatever its destination bits hold.
- R5: A destination of register zero never causes a bypass or a stall. An operand that reads register zero always takes select 2'b00.
- R6: When the execute stage holds a load with write-enable 1 whose nonzero destination equals a used source of the decode instruction (either rs or rt), the unit stalls. It drives pc_write=0 and ifid_write=0 and sets idex_ctrl_zero=1. With no stall these read 1, 1 and 0.
- R7: A source register whose use flag from decode is 0 never causes a stall.
- R8: A stall lasts at most one cycle. In the cycle that directly follows a stall cycle there is no stall, even if the inputs still show the hazard.
- R9: A matching producer in execute that is not a load (an ALU result) causes no stall.
- R10: After reset, with all inputs at zero, both selects read 2'b00 and there is no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| id_rs | input | REG_W | First source register of the decode instruction |
| id_rt | input | REG_W | Second source register of the decode instruction |
| id_rs_used | input | 1 | Decode instruction actually reads id_rs |
| id_rt_used | input | 1 | Decode instruction actually reads id_rt |
| ex_rs | input | REG_W | First source register of the execute instruction |
| ex_rt | input | REG_W | Second source register of the execute instruction |
| ex_rd | input | REG_W | Destination register of the execute instruction |
| ex_we | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| exm_rd | input | REG_W | Destination held in the execute/memory register |
| exm_we | input | 1 | Write-enable held in the execute/memory register |
| mwb_rd | input | REG_W | Destination held in the memory/writeback register |
| mwb_we | input | 1 | Write-enable held in the memory/writeback register |
| fwd_a_sel | output | 2 | Operand A source: 00 register file, 10 execute/memory, 01 memory/writeback |
| fwd_b_sel | output | 2 | Operand B source, same encoding |
| pc_write | output | 1 | Program counter may advance |
| ifid_write | output | 1 | Fetch/decode register may load |
| idex_ctrl_zero | output | 1 | Clear write-enable and memory-access bits entering execute |

## Verification
The bench puts both later stages on the same register to check the priority: a design that preferred the older stage would return 01 where 10 is due. Leftover destination bits on a producer with write-enable 0, and writes aimed at register zero, must both leave the selects at 00. A missing guard shows up there as a bypass of stale data. A load hazard held on the inputs for two cycles must stall only in the first cycle, or the pipeline would deadlock. An immediate-form consumer whose unused field matches the load, and an ALU producer that matches, must not stall at all.

// File: rtl/fwdu_pkg.sv
package fwdu_pkg;

   // Operand source encoding, shared by the selector and the bench
   typedef enum logic [1:0] {
      SRC_REGFILE = 2'b00,
      SRC_MEMWB   = 2'b01,
      SRC_EXMEM   = 2'b10
   } opnd_src_e;

   localparam int unsigned NUM_OPERANDS = 2;

endpackage

// File: rtl/fwdu_prod_hit.sv
// One producer-versus-source comparison, gated by write-enable and
// (optionally) the hardwired-zero register.
module fwdu_prod_hit #(
   parameter int unsigned REG_W     = 5,
   parameter bit          ZERO_HARD = 1'b1
) (
   input  logic [REG_W-1:0] src,
   input  logic [REG_W-1:0] dst,
   input  logic             dst_we,
   output logic             hit
);

   logic same_reg;
   assign same_reg = (src == dst);

   generate
      if (ZERO_HARD) begin : g_zero_guard
         assign hit = dst_we && (dst != '0) && same_reg;
      end else begin : g_no_zero_guard
         assign hit = dst_we && same_reg;
      end
   endgenerate

endmodule

// File: rtl/fwdu_opsel.sv
// Per-operand source selection: younger producer first.
module fwdu_opsel
   import fwdu_pkg::*;
#(
   parameter int unsigned REG_W     = 5,
   parameter bit          ZERO_HARD = 1'b1
) (
   input  logic [REG_W-1:0] src,
   input  logic [REG_W-1:0] exm_rd,
   input  logic             exm_we,
   input  logic [REG_W-1:0] mwb_rd,
   input  logic             mwb_we,
   output logic [1:0]       sel
);

   logic hit_young;
   logic hit_old;
   opnd_src_e choice;

   fwdu_prod_hit #(.REG_W(REG_W), .ZERO_HARD(ZERO_HARD)) u_young (
      .src(src), .dst(exm_rd), .dst_we(exm_we), .hit(hit_young)
   );

   fwdu_prod_hit #(.REG_W(REG_W), .ZERO_HARD(ZERO_HARD)) u_old (
      .src(src), .dst(mwb_rd), .dst_we(mwb_we), .hit(hit_old)
   );

   always_comb begin
      if (hit_young)      choice = SRC_EXMEM;
      else if (hit_old)   choice = SRC_MEMWB;
      else                choice = SRC_REGFILE;
   end

   assign sel = choice;

endmodule

// File: rtl/fwdu_loaduse.sv
// Load-in-execute versus decode-consumer detection with a one-cycle limiter.
module fwdu_loaduse #(
   parameter int unsigned REG_W     = 5,
   parameter bit          ZERO_HARD = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] id_rs,
   input  logic [REG_W-1:0] id_rt,
   input  logic             id_rs_used,
   input  logic             id_rt_used,
   input  logic [REG_W-1:0] ex_rd,
   input  logic             ex_we,
   input  logic             ex_is_load,
   output logic             stall
);

   logic [1:0] src_hit;
   logic [1:0] src_used;
   logic       raw_hazard;
   logic       stall_q;

   assign src_used = {id_rt_used, id_rs_used};

   fwdu_prod_hit #(.REG_W(REG_W), .ZERO_HARD(ZERO_HARD)) u_hit_rs (
      .src(id_rs), .dst(ex_rd), .dst_we(ex_we), .hit(src_hit[0])
   );

   fwdu_prod_hit #(.REG_W(REG_W), .ZERO_HARD(ZERO_HARD)) u_hit_rt (
      .src(id_rt), .dst(ex_rd), .dst_we(ex_we), .hit(src_hit[1])
   );

   assign raw_hazard = ex_is_load && |(src_hit & src_used);
   assign stall      = raw_hazard && !stall_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stall_q <= 1'b0;
      else        stall_q <= stall;
   end

endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit
   import fwdu_pkg::*;
#(
   parameter int unsigned REG_W     = 5,
   parameter bit          ZERO_HARD = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] id_rs,
   input  logic [REG_W-1:0] id_rt,
   input  logic             id_rs_used,
   input  logic             id_rt_used,
   input  logic [REG_W-1:0] ex_rs,
   input  logic [REG_W-1:0] ex_rt,
   input  logic [REG_W-1:0] ex_rd,
   input  logic             ex_we,
   input  logic             ex_is_load,
   input  logic [REG_W-1:0] exm_rd,
   input  logic             exm_we,
   input  logic [REG_W-1:0] mwb_rd,
   input  logic             mwb_we,
   output logic [1:0]       fwd_a_sel,
   output logic [1:0]       fwd_b_sel,
   output logic             pc_write,
   output logic             ifid_write,
   output logic             idex_ctrl_zero
);

   localparam int unsigned NREGS = 1 << REG_W;

   initial begin
      assert (REG_W >= 1 && REG_W <= 8)
         else $error("fwd_hazard_unit: REG_W must lie in 1..8");
      assert (NREGS >= 2)
         else $error("fwd_hazard_unit: at least two registers needed");
   end

   logic [REG_W-1:0] ex_src [NUM_OPERANDS];
   logic [1:0]       op_sel [NUM_OPERANDS];
   logic             stall;

   assign ex_src[0] = ex_rs;
   assign ex_src[1] = ex_rt;

   generate
      for (genvar g = 0; g < NUM_OPERANDS; g++) begin : g_opnd
         fwdu_opsel #(.REG_W(REG_W), .ZERO_HARD(ZERO_HARD)) u_sel (
            .src(ex_src[g]),
            .exm_rd(exm_rd), .exm_we(exm_we),
            .mwb_rd(mwb_rd), .mwb_we(mwb_we),
            .sel(op_sel[g])
         );
      end
   endgenerate

   assign fwd_a_sel = op_sel[0];
   assign fwd_b_sel = op_sel[1];

   fwdu_loaduse #(.REG_W(REG_W), .ZERO_HARD(ZERO_HARD)) u_lu (
      .clk(clk), .rst_n(rst_n),
      .id_rs(id_rs), .id_rt(id_rt),
      .id_rs_used(id_rs_used), .id_rt_used(id_rt_used),
      .ex_rd(ex_rd), .ex_we(ex_we), .ex_is_load(ex_is_load),
      .stall(stall)
   );

   assign pc_write       = !stall;
   assign ifid_write     = !stall;
   assign idex_ctrl_zero = stall;

endmodule

// File: rtl/fwdu_checker.sv
module fwdu_checker #(
   parameter int unsigned REG_W     = 5,
   parameter bit          ZERO_HARD = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [REG_W-1:0] id_rs,
   input logic [REG_W-1:0] id_rt,
   input logic             id_rs_used,
   input logic             id_rt_used,
   input logic [REG_W-1:0] ex_rs,
   input logic [REG_W-1:0] ex_rt,
   input logic [REG_W-1:0] ex_rd,
   input logic             ex_we,
   input logic             ex_is_load,
   input logic [REG_W-1:0] exm_rd,
   input logic             exm_we,
   input logic [REG_W-1:0] mwb_rd,
   input logic             mwb_we,
   input logic [1:0]       fwd_a_sel,
   input logic [1:0]       fwd_b_sel,
   input logic             pc_write,
   input logic             ifid_write,
   input logic             idex_ctrl_zero
);

   // R1 / R2: a matching younger producer always wins on operand A
   assert_young_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (exm_we && exm_rd != '0 && exm_rd == ex_rs) |-> fwd_a_sel == 2'b10);

   // R4: no enabled producer, no bypass on either operand
   assert_no_we_no_fwd_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!exm_we && !mwb_we) |-> (fwd_a_sel == 2'b00 && fwd_b_sel == 2'b00));

   // R5: reading register zero takes the register-file value
   assert_zero_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ZERO_HARD && ex_rt == '0) |-> fwd_b_sel == 2'b00);

   // R6: the three stall controls move together
   assert_stall_ctrl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_write == ifid_write) && (idex_ctrl_zero == !pc_write));

   // R8: never two stall cycles in a row
   assert_one_bubble_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !pc_write |=> pc_write);

   // R9: no load in execute, no stall
   assert_alu_no_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !ex_is_load |-> pc_write);

   // R3: selects only ever take one of the three defined codes
   assert_legal_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_a_sel != 2'b11) && (fwd_b_sel != 2'b11));

endmodule

bind fwd_hazard_unit fwdu_checker #(.REG_W(REG_W), .ZERO_HARD(ZERO_HARD)) u_chk (.*);

// File: tb/sim_fwd_hazard_unit.sv
module sim_fwd_hazard_unit;

   localparam int CLK_P = 10;
   localparam int RW    = 5;

   typedef struct {
      logic [RW-1:0] id_rs, id_rt;
      logic          id_rs_used, id_rt_used;
      logic [RW-1:0] ex_rs, ex_rt, ex_rd;
      logic          ex_we, ex_is_load;
      logic [RW-1:0] exm_rd;
      logic          exm_we;
      logic [RW-1:0] mwb_rd;
      logic          mwb_we;
   } vin_t;

   typedef struct {
      logic [1:0] a, b;
      logic       stall;
      string      tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   vin_t cur;

   logic [1:0] fwd_a_sel, fwd_b_sel;
   logic pc_write, ifid_write, idex_ctrl_zero;

   exp_t sb[$];
   int   n_chk = 0;
   int   n_bad = 0;
   bit   prev_stall = 1'b0;
   bit   finished = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   fwd_hazard_unit #(.REG_W(RW)) u0 (
      .clk(clk), .rst_n(rst_n),
      .id_rs(cur.id_rs), .id_rt(cur.id_rt),
      .id_rs_used(cur.id_rs_used), .id_rt_used(cur.id_rt_used),
      .ex_rs(cur.ex_rs), .ex_rt(cur.ex_rt), .ex_rd(cur.ex_rd),
      .ex_we(cur.ex_we), .ex_is_load(cur.ex_is_load),
      .exm_rd(cur.exm_rd), .exm_we(cur.exm_we),
      .mwb_rd(cur.mwb_rd), .mwb_we(cur.mwb_we),
      .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel),
      .pc_write(pc_write), .ifid_write(ifid_write),
      .idex_ctrl_zero(idex_ctrl_zero)
   );

   function automatic vin_t idle();
      vin_t v;
      v = '{default: '0};
      return v;
   endfunction

   // Expected select from the requirement text (R1, R2, R4, R5)
   function automatic logic [1:0] want_sel(logic [RW-1:0] s, vin_t v);
      if (v.exm_we && v.exm_rd != 0 && v.exm_rd == s) return 2'b10;
      if (v.mwb_we && v.mwb_rd != 0 && v.mwb_rd == s) return 2'b01;
      return 2'b00;
   endfunction

   task automatic apply(input string tag, input vin_t v);
      exp_t e;
      bit   hz;
      @(negedge clk);
      cur = v;
      hz = v.ex_is_load && v.ex_we && v.ex_rd != 0 &&
           ((v.id_rs_used && v.id_rs == v.ex_rd) ||
            (v.id_rt_used && v.id_rt == v.ex_rd));
      e.a     = want_sel(v.ex_rs, v);
      e.b     = want_sel(v.ex_rt, v);
      e.stall = hz && !prev_stall;
      e.tag   = tag;
      prev_stall = rst_n ? e.stall : 1'b0;
      sb.push_back(e);
   endtask

   // Monitor: compares a quarter period after the driver's edge
   initial begin
      exp_t e;
      forever begin
         @(negedge clk);
         #(CLK_P/4);
         if (sb.size() > 0) begin
            e = sb.pop_front();
            n_chk++;
            if (fwd_a_sel !== e.a || fwd_b_sel !== e.b ||
                pc_write !== !e.stall || ifid_write !== !e.stall ||
                idex_ctrl_zero !== e.stall) begin
               n_bad++;
               $display("FAIL %s: got a=%b b=%b pcw=%b ifw=%b cz=%b, want a=%b b=%b pcw=%b ifw=%b cz=%b",
                        e.tag, fwd_a_sel, fwd_b_sel, pc_write, ifid_write, idex_ctrl_zero,
                        e.a, e.b, !e.stall, !e.stall, e.stall);
            end
         end
      end
   end

   initial begin
      #(CLK_P * 5000);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: got hung run, want completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      vin_t v;
      cur = idle();
      apply("R10 in reset", idle());
      @(negedge clk);
      rst_n = 1'b1;
      apply("R10 after reset", idle());

      v = idle(); v.ex_rs = 3; v.exm_rd = 3; v.exm_we = 1;
      apply("R1 exmem bypass A", v);

      v = idle(); v.ex_rt = 4; v.mwb_rd = 4; v.mwb_we = 1;
      apply("R2 memwb bypass B", v);

      v = idle(); v.ex_rs = 5; v.exm_rd = 5; v.exm_we = 1; v.mwb_rd = 5; v.mwb_we = 1;
      apply("R2 younger wins", v);

      v = idle(); v.ex_rs = 6; v.ex_rt = 7; v.exm_rd = 7; v.exm_we = 1; v.mwb_rd = 6; v.mwb_we = 1;
      apply("R3 split sources", v);

      v = idle(); v.ex_rs = 8; v.ex_rt = 8; v.exm_rd = 8; v.exm_we = 1;
      apply("R3 same source both", v);

      v = idle(); v.ex_rs = 9; v.ex_rt = 9; v.exm_rd = 9; v.mwb_rd = 9;
      apply("R4 stale bits no we", v);

      v = idle(); v.ex_rs = 9; v.exm_rd = 9; v.mwb_rd = 9; v.mwb_we = 1;
      apply("R4 skip disabled young", v);

      v = idle(); v.exm_rd = 0; v.exm_we = 1; v.mwb_rd = 0; v.mwb_we = 1;
      apply("R5 zero dest no fwd", v);

      v = idle(); v.id_rs = 10; v.id_rs_used = 1; v.ex_rd = 10; v.ex_we = 1; v.ex_is_load = 1;
      apply("R6 load-use rs", v);

      v = idle(); v.id_rs = 10; v.id_rs_used = 1;
      apply("R8 bubble in ex", v);

      v = idle(); v.ex_rs = 10; v.mwb_rd = 10; v.mwb_we = 1;
      apply("R2 load data via memwb", v);

      v = idle(); v.id_rt = 11; v.id_rt_used = 1; v.ex_rd = 11; v.ex_we = 1; v.ex_is_load = 1;
      apply("R6 load-use rt", v);
      apply("R8 held hazard", v);
      apply("R8 held third cycle", v);

      apply("R10 idle", idle());
      v = idle(); v.id_rt = 12; v.id_rt_used = 0; v.id_rs = 3; v.id_rs_used = 1;
      v.ex_rd = 12; v.ex_we = 1; v.ex_is_load = 1;
      apply("R7 unused field", v);

      v = idle(); v.id_rs = 0; v.id_rs_used = 1; v.ex_rd = 0; v.ex_we = 1; v.ex_is_load = 1;
      apply("R5 load to zero", v);

      v = idle(); v.id_rs = 13; v.id_rs_used = 1; v.ex_rd = 13; v.ex_we = 1;
      v.ex_rs = 13; v.exm_rd = 13; v.exm_we = 1;
      apply("R9 alu producer", v);

      v = idle(); v.id_rs = 14; v.id_rs_used = 1; v.ex_rd = 14; v.ex_we = 0; v.ex_is_load = 1;
      apply("R4 load no we", v);

      repeat (3) @(negedge clk);
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule